// File: doc/BRIEF.md
# RC5 Subkey Table Generator

This block turns a 128-bit secret key into the table of 26 round subkeys that an RC5 cipher with 32-bit words and 12 rounds needs. A one-cycle `start` pulse captures the key and begins two back-to-back phases. The first phase writes an arithmetic progression seeded by two fixed odd constants into the table. The second phase runs a mixing loop that stirs the key words into the table, using data-dependent rotations.

The whole job goes through one registered arithmetic step, which performs one table write per clock. `ready` therefore stays low for 104 cycles after `start` and then rises. From then on, the cipher datapath reads any table entry through a combinational read port addressed by `rd_addr`.

Top module: `rc5_keysched`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `ready` goes low and every table entry clears to zero, so `rd_data` reads 0 at every address.
- R2: At the edge where `start` is sampled high, the key is split into four 32-bit words in little-endian order: word j is `key_in[32*j+31 : 32*j]`, so key byte 0 is the least significant byte of word 0.
- R3: In the 26 cycles after `start`, entry k is written with 0xB7E15163 + k * 0x9E3779B9 (mod 2^32). After the 26th edge that follows `start`, and before the next edge, entry k holds exactly that value.
- R4: The next 78 cycles each perform one mix step, with registers A and B and indices i and j all starting at 0. Each step sets A = S[i] = rotl(S[i] + A + B, 3), then B = L[j] = rotl(L[j] + A + B, (A + B) mod 32), then sets i = (i + 1) mod 26 and j = (j + 1) mod 4.
- R5: `ready` is low in the cycle after any `start`. It rises at exactly the 104th rising edge after the edge that sampled `start`, and it stays high until the next `start`.
- R6: A `start` sampled during an expansion abandons that expansion. A full 104-cycle expansion then runs on the newly presented key.
- R7: `rd_data` is a combinational read of entry `rd_addr`. Any `rd_addr` of 26 or more reads 0.
- R8: While `ready` is high and `start` is low, the table does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse: capture key and begin expansion |
| key_in | input | 128 | Secret key, byte 0 in bits 7:0 |
| rd_addr | input | 5 | Table read address |
| rd_data | output | 32 | Table entry at `rd_addr` |
| ready | output | 1 | Table is complete and stable |

## Verification
The assertions take two things for granted. First, `start` arrives only as an isolated one-cycle pulse. Second, `rd_addr` is held steady for at least a cycle whenever table stability is being judged. The stimulus keeps to both: it raises `start` for exactly one clock per expansion, including the restart issued mid-expansion, and it changes `rd_addr` only on falling edges while reading back the finished table. The key words themselves are left unconstrained. Zero, all-ones and mixed keys are all used, so that rotation amounts of zero and of large values both occur.

// File: rtl/rc5_ks_pkg.sv
// Shared types, constants and helpers for the RC5 subkey table generator.
// Assumes 32-bit words; the seed constants are defined for that width only.
package rc5_ks_pkg;
    localparam int WORD_W = 32;
    localparam int ROT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t SEED_P = 32'hB7E15163;
    localparam word_t STEP_Q = 32'h9E3779B9;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_MIX  = 2'd2
    } phase_e;

    // Left rotate by the low ROT_W bits of the amount.
    function automatic word_t rotl(input word_t x, input logic [ROT_W-1:0] sh);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << sh;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction
endpackage

// File: rtl/rc5_ks_regfile.sv
// Flop-based word register file with one write port, an optional parallel
// load of every entry, and all contents exposed flat for muxing elsewhere.
// Assumes load and write are never needed in the same cycle; load wins.
module rc5_ks_regfile #(
    parameter int DEPTH = 26,
    parameter int AW    = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 load_en,
    input  logic [DEPTH*rc5_ks_pkg::WORD_W-1:0]  load_data,
    input  logic                                 we,
    input  logic [AW-1:0]                        waddr,
    input  rc5_ks_pkg::word_t                    wdata,
    output logic [DEPTH*rc5_ks_pkg::WORD_W-1:0]  q_all
);
    import rc5_ks_pkg::*;

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        word_t ent_q;

        // Hold one entry: clear on reset, bulk load, or addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (load_en) begin
                ent_q <= load_data[k*WORD_W +: WORD_W];
            end else if (we && (waddr == AW'(k))) begin
                ent_q <= wdata;
            end
        end

        assign q_all[k*WORD_W +: WORD_W] = ent_q;
    end
endmodule

// File: rtl/rc5_ks_ctrl.sv
// Sequencer for the expansion: walks the table once to fill it, then runs
// the mix loop for MIX_STEPS steps while stepping both indices, then
// raises ready. A start in any phase restarts from the fill phase.
module rc5_ks_ctrl #(
    parameter int TBL       = 26,
    parameter int KW        = 4,
    parameter int MIX_STEPS = 78,
    parameter int IDX_W     = 5,
    parameter int JW        = 2,
    parameter int CNT_W     = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output rc5_ks_pkg::phase_e  phase,
    output logic [IDX_W-1:0]    s_idx,
    output logic [JW-1:0]       l_idx,
    output logic                ready
);
    import rc5_ks_pkg::*;

    localparam logic [IDX_W-1:0] LAST_S    = IDX_W'(TBL - 1);
    localparam logic [JW-1:0]    LAST_L    = JW'(KW - 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MIX_STEPS - 1);

    logic [CNT_W-1:0] step_q;

    // Advance phase, indices and step count; flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            s_idx  <= '0;
            l_idx  <= '0;
            step_q <= '0;
            ready  <= 1'b0;
        end else if (start) begin
            phase  <= PH_FILL;
            s_idx  <= '0;
            l_idx  <= '0;
            step_q <= '0;
            ready  <= 1'b0;
        end else begin
            case (phase)
                PH_FILL: begin
                    if (s_idx == LAST_S) begin
                        s_idx <= '0;
                        phase <= PH_MIX;
                    end else begin
                        s_idx <= s_idx + 1'b1;
                    end
                end
                PH_MIX: begin
                    s_idx <= (s_idx == LAST_S) ? '0 : s_idx + 1'b1;
                    l_idx <= (l_idx == LAST_L) ? '0 : l_idx + 1'b1;
                    if (step_q == LAST_STEP) begin
                        step_q <= '0;
                        phase  <= PH_IDLE;
                        ready  <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rc5_ks_mix.sv
// The single shared arithmetic step. In the fill phase it supplies the
// running progression value. In the mix phase it computes the new A and B
// from the current table and key words, and keeps them in registers for
// the next step. Assumes the sequencer presents S[i] and L[j] for the
// current indices in the same cycle.
module rc5_ks_mix (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  rc5_ks_pkg::phase_e phase,
    input  rc5_ks_pkg::word_t  s_cur,
    input  rc5_ks_pkg::word_t  l_cur,
    output logic               s_we,
    output rc5_ks_pkg::word_t  s_wdata,
    output logic               l_we,
    output rc5_ks_pkg::word_t  l_wdata
);
    import rc5_ks_pkg::*;

    word_t a_q, b_q, fill_q;
    word_t a_new, ab_sum, b_new;

    // One mix step: A from the table word, then B from the key word.
    always_comb begin
        a_new  = rotl(s_cur + a_q + b_q, ROT_W'(3));
        ab_sum = a_new + b_q;
        b_new  = rotl(l_cur + ab_sum, ab_sum[ROT_W-1:0]);
    end

    // Hold A, B and the progression value between steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            fill_q <= '0;
        end else if (start) begin
            a_q    <= '0;
            b_q    <= '0;
            fill_q <= SEED_P;
        end else if (phase == PH_FILL) begin
            fill_q <= fill_q + STEP_Q;
        end else if (phase == PH_MIX) begin
            a_q <= a_new;
            b_q <= b_new;
        end
    end

    // Route the step result to the two register files.
    always_comb begin
        s_we    = (phase == PH_FILL) || (phase == PH_MIX);
        s_wdata = (phase == PH_FILL) ? fill_q : a_new;
        l_we    = (phase == PH_MIX);
        l_wdata = b_new;
    end
endmodule

// File: rtl/rc5_keysched.sv
// Top of the RC5 subkey table generator. Captures the key on start, fills
// and mixes the subkey table one word per cycle, and serves table reads.
// Assumes start is a single-cycle pulse; reads are valid once ready is high.
module rc5_keysched #(
    parameter int ROUNDS    = 12,
    parameter int KEY_WORDS = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     start,
    input  logic [KEY_WORDS*32-1:0]                  key_in,
    input  logic [$clog2(2*(ROUNDS+1))-1:0]          rd_addr,
    output logic [31:0]                              rd_data,
    output logic                                     ready
);
    import rc5_ks_pkg::*;

    localparam int TBL       = 2 * (ROUNDS + 1);
    localparam int IDX_W     = $clog2(TBL);
    localparam int JW        = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
    localparam int MIX_STEPS = 3 * ((TBL > KEY_WORDS) ? TBL : KEY_WORDS);
    localparam int CNT_W     = $clog2(MIX_STEPS + 1);

    phase_e                      phase;
    logic [IDX_W-1:0]            s_idx;
    logic [JW-1:0]               l_idx;
    logic [TBL*WORD_W-1:0]       s_all;
    logic [KEY_WORDS*WORD_W-1:0] l_all;
    word_t                       s_cur, l_cur, s_wdata, l_wdata;
    logic                        s_we, l_we;

    rc5_ks_ctrl #(
        .TBL(TBL), .KW(KEY_WORDS), .MIX_STEPS(MIX_STEPS),
        .IDX_W(IDX_W), .JW(JW), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .phase(phase), .s_idx(s_idx), .l_idx(l_idx), .ready(ready)
    );

    rc5_ks_mix u_mix (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
        .s_cur(s_cur), .l_cur(l_cur),
        .s_we(s_we), .s_wdata(s_wdata), .l_we(l_we), .l_wdata(l_wdata)
    );

    rc5_ks_regfile #(.DEPTH(TBL), .AW(IDX_W)) u_stab (
        .clk(clk), .rst_n(rst_n),
        .load_en(1'b0), .load_data('0),
        .we(s_we), .waddr(s_idx), .wdata(s_wdata), .q_all(s_all)
    );

    rc5_ks_regfile #(.DEPTH(KEY_WORDS), .AW(JW)) u_ltab (
        .clk(clk), .rst_n(rst_n),
        .load_en(start), .load_data(key_in),
        .we(l_we), .waddr(l_idx), .wdata(l_wdata), .q_all(l_all)
    );

    // Select the table and key words at the working indices.
    always_comb begin
        s_cur = '0;
        for (int k = 0; k < TBL; k++) begin
            if (s_idx == IDX_W'(k)) s_cur = s_all[k*WORD_W +: WORD_W];
        end
        l_cur = '0;
        for (int k = 0; k < KEY_WORDS; k++) begin
            if (l_idx == JW'(k)) l_cur = l_all[k*WORD_W +: WORD_W];
        end
    end

    // External read port; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < TBL; k++) begin
            if (rd_addr == IDX_W'(k)) rd_data = s_all[k*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/rc5_keysched_chk.sv
// Property checker for rc5_keysched, bound to every instance. It counts the
// cycles since the last start itself so that the latency is checked without
// a long $past window.
module rc5_keysched_chk #(
    parameter int ROUNDS    = 12,
    parameter int KEY_WORDS = 4
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 start,
    input logic [$clog2(2*(ROUNDS+1))-1:0]      rd_addr,
    input logic [31:0]                          rd_data,
    input logic                                 ready
);
    localparam int TBL     = 2 * (ROUNDS + 1);
    localparam int LATENCY = TBL + 3 * ((TBL > KEY_WORDS) ? TBL : KEY_WORDS);

    logic [8:0] since_start;

    // Cycles elapsed since the edge that sampled start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_start <= '1;
        else if (start)              since_start <= '0;
        else if (since_start != '1)  since_start <= since_start + 1'b1;
    end

    // R5
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    // R5
    ready_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (since_start == 9'(LATENCY)));

    // R8
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ($stable(rd_data) || !$stable(rd_addr)));

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= ($clog2(TBL))'(TBL)) |-> (rd_data == 32'd0));
endmodule

bind rc5_keysched rc5_keysched_chk #(
    .ROUNDS(ROUNDS), .KEY_WORDS(KEY_WORDS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
);

// File: tb/test_rc5_keysched.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each expansion and queues the
// expected table; the monitor walks the read port and compares.
module test_rc5_keysched;
    localparam logic [31:0] P = 32'hB7E15163;
    localparam logic [31:0] Q = 32'h9E3779B9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key_in = '0;
    logic [4:0]   rd_addr;
    logic [31:0]  rd_data;
    logic         ready;

    logic [4:0]   mon_addr = '0;
    logic [4:0]   probe_addr = '0;
    logic         mon_on = 1'b0;
    logic [31:0]  exp_q[$];
    logic [31:0]  m_s [26];
    int           n_chk = 0;
    int           n_bad = 0;

    assign rd_addr = mon_on ? mon_addr : probe_addr;

    always #2 clk = ~clk;

    rc5_keysched i_rc5_keysched (
        .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in),
        .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
    endfunction

    // Reference model of the whole expansion, straight from R2..R4.
    task automatic model(input logic [127:0] key);
        logic [31:0] l [4];
        logic [31:0] a, b, ab;
        int i, j;
        for (int k = 0; k < 4; k++) l[k] = key[32*k +: 32];
        m_s[0] = P;
        for (int k = 1; k < 26; k++) m_s[k] = m_s[k-1] + Q;
        a = '0; b = '0; i = 0; j = 0;
        for (int s = 0; s < 78; s++) begin
            a = rl(m_s[i] + a + b, 3);
            m_s[i] = a;
            ab = a + b;
            b = rl(l[j] + ab, int'(ab[4:0]));
            l[j] = b;
            i = (i + 1) % 26;
            j = (j + 1) % 4;
        end
    endtask

    // Pulse start with a key, time ready, and probe the filled table.
    task automatic expand(input logic [127:0] key);
        int cyc;
        @(negedge clk);
        key_in = key;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!ready && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) chk("R5 ready low after start", {31'd0, ready}, 32'd0);
            if (cyc == 26) begin
                probe_addr = 5'd25; #1;
                chk("R3 fill entry 25", rd_data, P + 32'd25 * Q);
                probe_addr = 5'd3; #1;
                chk("R3 fill entry 3", rd_data, P + 32'd3 * Q);
            end
        end
        chk("R5 ready latency", cyc, 32'd104);
    endtask

    // Queue the expected table and let the monitor drain it.
    task automatic score(input logic [127:0] key);
        model(key);
        for (int k = 0; k < 26; k++) exp_q.push_back(m_s[k]);
        mon_addr = '0;
        @(negedge clk); #1;
        mon_on = 1'b1;
        wait (mon_on == 1'b0);
    endtask

    // Monitor: compare each table word against the scoreboard (R2, R4, R6).
    always @(negedge clk) begin
        if (mon_on) begin
            chk($sformatf("R4 table entry %0d", mon_addr), rd_data, exp_q.pop_front());
            mon_addr = mon_addr + 1'b1;
            if (exp_q.size() == 0) mon_on = 1'b0;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", {31'd0, ready}, 32'd0);
        probe_addr = 5'd0;  #1; chk("R1 entry 0 cleared", rd_data, 32'd0);
        probe_addr = 5'd25; #1; chk("R1 entry 25 cleared", rd_data, 32'd0);
        rst_n = 1'b1;

        expand(128'd0);
        score(128'd0);

        // R2: distinct bytes expose little-endian word order
        expand(128'h0F0E0D0C_0B0A0908_07060504_03020100);
        score(128'h0F0E0D0C_0B0A0908_07060504_03020100);

        expand({128{1'b1}});
        score({128{1'b1}});

        // R6: restart mid-expansion with a different key
        @(negedge clk);
        key_in = 128'h91CC2F07_55AA0011_DEADBEEF_12345678;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        expand(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        score(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);

        // R8: table unchanged while ready and idle
        probe_addr = 5'd7; #1;
        repeat (12) @(negedge clk);
        chk("R8 entry 7 held", rd_data, m_s[7]);
        chk("R5 ready held high", {31'd0, ready}, 32'd1);

        // R7: unmapped addresses
        probe_addr = 5'd26; #1; chk("R7 addr 26 reads zero", rd_data, 32'd0);
        probe_addr = 5'd31; #1; chk("R7 addr 31 reads zero", rd_data, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R5 watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule